// File: doc/BRIEF.md
# Store Buffer Drain Timing Tracker

This block keeps timing books for a bounded store buffer without carrying any store data. Each store the core issues is queued as the number of memory cycles it still needs. The oldest entries are worn down by the cycles that pass between requests. A free-running cycle count comes in as an input. When a request is accepted, the block measures the time since its last update and retires every oldest entry that this time fully covers, in order. Any cycles left over are taken off the remaining cost of the new oldest entry.

A store that finds the buffer at its configured length forces the oldest entry to finish first. A load must wait until the buffer has drained completely. In both cases the block raises a stall output for exactly the number of cycles the core has to wait. It also advances its update stamp by the same amount, so that waited time is not counted a second time. Two saturating counters accumulate the total waited cycles and the total store cycles issued. They serve as performance figures for the surrounding model.

Top module: `sbt_tracker`

## Requirements
- R1: After reset, stall is low, both counters read 0, the queue is empty and the update stamp is 0.
- R2: On an accepted request, the elapsed cycles (cycle_now minus the stamp, modulo 2^TIME_W) retire queued costs oldest first while the remaining elapsed count is at least the entry's cost, possibly several entries in one cycle. Any remainder is subtracted from the oldest surviving entry.
- R3: A store that finds fewer than the effective length of entries queued (counted after R2 retirement) is queued at the newest position with no stall.
- R4: A store that finds the queue non-empty and at or above the effective length after R2 waits for the oldest entry only. That entry's remaining cost is the wait, it is removed, and the new cost is then queued.
- R5: A load (ld_req = 1) waits for the sum of all remaining costs after R2 and leaves the queue empty. A load on an empty queue causes no stall.
- R6: stall rises in the cycle after an accepting edge and stays high for exactly the wait that edge added. Requests seen while stall is high are ignored and change no counter or queue state.
- R7: The effective length is len_cfg clamped to DEPTH. With an effective length of 0, each store forces out the single entry queued before it.
- R8: store_total increases by st_cost for every accepted store.
- R9: wait_total increases by every wait added under R4 and R5. The update stamp moves forward by the same amount.
- R10: Both counters saturate at 2^CNT_W - 1 instead of wrapping.
- R11: When st_req and ld_req are both high on an accepting edge, the load is performed and the store is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_now | input | TIME_W | Free-running cycle count |
| st_req | input | 1 | Store request |
| st_cost | input | COST_W | Memory cycles the store needs |
| ld_req | input | 1 | Load request |
| len_cfg | input | LEN_W | Configured buffer length limit |
| stall | output | 1 | Core must wait |
| wait_total | output | CNT_W | Saturating count of waited cycles |
| store_total | output | CNT_W | Saturating count of store cycles |

## Verification
Retirement of elapsed entries and the full-buffer eviction both happen on the same accepting edge. The eviction must act on the entry the retirement leaves behind, already reduced by the leftover time. The bench sets this up by spacing stores so that the elapsed time partly consumes the oldest cost just as the queue reaches its length. It then judges the stall length, which must equal that reduced cost, and the stamp advance it implies, which shows up in the next request's retirement. Load and store arriving together on one edge are also driven, and the dropped store is exposed by a following load that must see an empty queue.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  // Circular index step: (base + off) mod depth
  function automatic int unsigned ring_idx(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/sbt_drain.sv
module sbt_drain #(
  parameter int DEPTH  = 4,
  parameter int COST_W = 8,
  parameter int TIME_W = 16,
  parameter int PTR_W  = 2,
  parameter int CQ_W   = 3,
  parameter int SUM_W  = 11
) (
  input  logic [DEPTH-1:0][COST_W-1:0] slots,
  input  logic [PTR_W-1:0]             tail,
  input  logic [CQ_W-1:0]              cnt,
  input  logic [TIME_W-1:0]            delta,
  output logic [PTR_W-1:0]             mid_tail,
  output logic [CQ_W-1:0]              mid_cnt,
  output logic [COST_W-1:0]            tail_adj,
  output logic [SUM_W-1:0]             left_sum
);
  always_comb begin
    logic [TIME_W-1:0] rem;
    logic [CQ_W-1:0]   ret;
    logic              stop;
    logic [PTR_W-1:0]  idx;
    rem  = delta;
    ret  = '0;
    stop = 1'b0;
    // retire whole oldest entries while elapsed time covers them
    for (int i = 0; i < DEPTH; i++) begin
      idx = PTR_W'(sbt_pkg::ring_idx(32'(tail), 32'(i), DEPTH));
      if (!stop && (CQ_W'(i) < cnt) && (rem >= TIME_W'(slots[idx]))) begin
        rem = rem - TIME_W'(slots[idx]);
        ret = ret + CQ_W'(1);
      end else begin
        stop = 1'b1;
      end
    end
    mid_tail = PTR_W'(sbt_pkg::ring_idx(32'(tail), 32'(ret), DEPTH));
    mid_cnt  = cnt - ret;
    // leftover time is smaller than the surviving oldest cost
    if (mid_cnt != '0) tail_adj = slots[mid_tail] - COST_W'(rem);
    else               tail_adj = '0;
    left_sum = SUM_W'(tail_adj);
    for (int j = 1; j < DEPTH; j++) begin
      idx = PTR_W'(sbt_pkg::ring_idx(32'(mid_tail), 32'(j), DEPTH));
      if (CQ_W'(j) < mid_cnt) left_sum = left_sum + SUM_W'(slots[idx]);
    end
  end
endmodule

// File: rtl/sbt_satacc.sv
module sbt_satacc #(
  parameter int W    = 32,
  parameter int IN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] add,
  output logic [W-1:0]    total
);
  localparam int SW = ((W > IN_W) ? W : IN_W) + 1;
  localparam logic [SW-1:0] TOP = SW'({W{1'b1}});

  logic [SW-1:0] sum;
  logic [W-1:0]  total_d;

  always_comb begin
    sum = SW'(total) + SW'(add);
    if (sum > TOP) total_d = {W{1'b1}};
    else           total_d = W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  total <= '0;
    else if (en) total <= total_d;
  end
endmodule

// File: rtl/sbt_tracker.sv
module sbt_tracker #(
  parameter int DEPTH  = 4,
  parameter int COST_W = 8,
  parameter int TIME_W = 16,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] cycle_now,
  input  logic              st_req,
  input  logic [COST_W-1:0] st_cost,
  input  logic              ld_req,
  input  logic [LEN_W-1:0]  len_cfg,
  output logic              stall,
  output logic [CNT_W-1:0]  wait_total,
  output logic [CNT_W-1:0]  store_total
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CQ_W  = $clog2(DEPTH + 1);
  localparam int SUM_W = COST_W + $clog2(DEPTH) + 1;

  logic [DEPTH-1:0][COST_W-1:0] slot_q, slot_d;
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CQ_W-1:0]   cnt_q, cnt_d;
  logic [TIME_W-1:0] stamp_q, stamp_d;
  logic [SUM_W-1:0]  hold_q, hold_d;

  logic              accept, take_ld, take_st;
  logic [TIME_W-1:0] delta;
  logic [PTR_W-1:0]  mid_tail;
  logic [CQ_W-1:0]   mid_cnt;
  logic [COST_W-1:0] tail_adj;
  logic [SUM_W-1:0]  left_sum, add_wait;
  logic [CQ_W-1:0]   len_eff;

  assign stall   = (hold_q != '0);
  assign accept  = !stall && (st_req || ld_req);
  assign take_ld = accept && ld_req;
  assign take_st = accept && st_req && !ld_req;
  assign delta   = cycle_now - stamp_q;
  assign len_eff = (len_cfg > LEN_W'(DEPTH)) ? CQ_W'(DEPTH) : CQ_W'(len_cfg);

  sbt_drain #(
    .DEPTH(DEPTH), .COST_W(COST_W), .TIME_W(TIME_W),
    .PTR_W(PTR_W), .CQ_W(CQ_W), .SUM_W(SUM_W)
  ) u_drain (
    .slots(slot_q), .tail(tail_q), .cnt(cnt_q), .delta(delta),
    .mid_tail(mid_tail), .mid_cnt(mid_cnt),
    .tail_adj(tail_adj), .left_sum(left_sum)
  );

  // next-state
  always_comb begin
    slot_d   = slot_q;
    head_d   = head_q;
    tail_d   = tail_q;
    cnt_d    = cnt_q;
    stamp_d  = stamp_q;
    add_wait = '0;
    hold_d   = stall ? (hold_q - SUM_W'(1)) : '0;
    if (take_ld) begin
      add_wait = left_sum;
      tail_d   = head_q;
      cnt_d    = '0;
      stamp_d  = cycle_now + TIME_W'(left_sum);
      hold_d   = left_sum;
    end else if (take_st) begin
      tail_d  = mid_tail;
      cnt_d   = mid_cnt;
      stamp_d = cycle_now;
      if (mid_cnt != '0) slot_d[mid_tail] = tail_adj;
      if ((mid_cnt != '0) && (mid_cnt >= len_eff)) begin
        add_wait = SUM_W'(tail_adj);
        stamp_d  = cycle_now + TIME_W'(tail_adj);
        tail_d   = PTR_W'(sbt_pkg::ring_idx(32'(mid_tail), 32'd1, DEPTH));
        cnt_d    = mid_cnt - CQ_W'(1);
        hold_d   = SUM_W'(tail_adj);
      end
      slot_d[head_q] = st_cost;
      head_d = PTR_W'(sbt_pkg::ring_idx(32'(head_q), 32'd1, DEPTH));
      cnt_d  = cnt_d + CQ_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      stamp_q <= '0;
      hold_q  <= '0;
    end else begin
      hold_q <= hold_d;
      if (accept) begin
        slot_q  <= slot_d;
        head_q  <= head_d;
        tail_q  <= tail_d;
        cnt_q   <= cnt_d;
        stamp_q <= stamp_d;
      end
    end
  end

  sbt_satacc #(.W(CNT_W), .IN_W(SUM_W)) u_wait_acc (
    .clk(clk), .rst_n(rst_n), .en(take_ld || take_st),
    .add(add_wait), .total(wait_total)
  );

  sbt_satacc #(.W(CNT_W), .IN_W(COST_W)) u_store_acc (
    .clk(clk), .rst_n(rst_n), .en(take_st),
    .add(st_cost), .total(store_total)
  );
endmodule

// File: rtl/sbt_tracker_chk.sv
module sbt_tracker_chk #(
  parameter int DEPTH = 4,
  parameter int CQ_W  = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_req,
  input logic             ld_req,
  input logic             stall,
  input logic [CQ_W-1:0]  cnt_q,
  input logic [CQ_W-1:0]  len_eff,
  input logic [CNT_W-1:0] wait_total,
  input logic [CNT_W-1:0] store_total
);
  a_r6_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(store_total));
  a_r6_wait_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(wait_total));
  a_r6_stall_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(st_req || ld_req));
  a_r3_no_stall_below: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !ld_req && !stall && (cnt_q < len_eff)) |=> !stall);
  a_r11_store_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && ld_req && !stall) |=> $stable(store_total));
  a_r8_store_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (store_total >= $past(store_total)));
  a_r9_wait_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wait_total >= $past(wait_total)));
  a_r10_store_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (store_total == {CNT_W{1'b1}}) |=> (store_total == {CNT_W{1'b1}}));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CQ_W'(DEPTH));
endmodule

bind sbt_tracker sbt_tracker_chk #(.DEPTH(DEPTH), .CQ_W(CQ_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_req(st_req), .ld_req(ld_req), .stall(stall),
  .cnt_q(cnt_q), .len_eff(len_eff), .wait_total(wait_total),
  .store_total(store_total)
);

// File: tb/tb_sbt_tracker.sv
module tb_sbt_tracker;
  localparam int DEPTH  = 4;
  localparam int COST_W = 8;
  localparam int TIME_W = 16;
  localparam int LEN_W  = 4;
  localparam int CNT_W  = 12;
  localparam logic [1:0] OP_ST = 2'd1, OP_LD = 2'd2, OP_BOTH = 2'd3;

  typedef struct packed {
    logic [15:0] tgt;
    logic [1:0]  op;
    logic [7:0]  cost;
    logic [3:0]  len;
    logic        poke;
    logic [7:0]  exp_stall;
    logic [11:0] exp_wt;
    logic [11:0] exp_st;
  } row_t;

  localparam int NROW = 21;
  localparam row_t ROWS [NROW] = '{
    '{16'd20,  OP_ST,   8'd10, 4'd2, 1'b0, 8'd0,  12'd0,   12'd10},  // R3 empty queue
    '{16'd22,  OP_ST,   8'd5,  4'd2, 1'b0, 8'd0,  12'd0,   12'd15},  // R2 partial wear
    '{16'd24,  OP_ST,   8'd7,  4'd2, 1'b1, 8'd6,  12'd6,   12'd22},  // R4 evict worn head
    '{16'd40,  OP_ST,   8'd3,  4'd2, 1'b0, 8'd0,  12'd6,   12'd25},  // R2 retire one, wear next
    '{16'd42,  OP_LD,   8'd0,  4'd2, 1'b0, 8'd3,  12'd9,   12'd25},  // R5 drain
    '{16'd50,  OP_LD,   8'd0,  4'd2, 1'b0, 8'd0,  12'd9,   12'd25},  // R5 empty load
    '{16'd51,  OP_ST,   8'd4,  4'd2, 1'b0, 8'd0,  12'd9,   12'd29},
    '{16'd52,  OP_ST,   8'd4,  4'd2, 1'b0, 8'd0,  12'd9,   12'd33},
    '{16'd60,  OP_ST,   8'd9,  4'd2, 1'b0, 8'd0,  12'd9,   12'd42},  // R2 two retired at once
    '{16'd61,  OP_ST,   8'd2,  4'd2, 1'b0, 8'd0,  12'd9,   12'd44},
    '{16'd62,  OP_LD,   8'd0,  4'd2, 1'b0, 8'd9,  12'd18,  12'd44},  // R5 sum of two
    '{16'd80,  OP_ST,   8'd20, 4'd7, 1'b0, 8'd0,  12'd18,  12'd64},  // R7 clamp to 4
    '{16'd81,  OP_ST,   8'd20, 4'd7, 1'b0, 8'd0,  12'd18,  12'd84},
    '{16'd82,  OP_ST,   8'd20, 4'd7, 1'b0, 8'd0,  12'd18,  12'd104},
    '{16'd83,  OP_ST,   8'd20, 4'd7, 1'b0, 8'd0,  12'd18,  12'd124},
    '{16'd84,  OP_ST,   8'd20, 4'd7, 1'b0, 8'd16, 12'd34,  12'd144}, // R7 full at DEPTH
    '{16'd110, OP_LD,   8'd0,  4'd7, 1'b1, 8'd70, 12'd104, 12'd144}, // R5 full drain
    '{16'd200, OP_ST,   8'd5,  4'd0, 1'b0, 8'd0,  12'd104, 12'd149}, // R7 length zero
    '{16'd201, OP_ST,   8'd5,  4'd0, 1'b0, 8'd4,  12'd108, 12'd154}, // R7 forces previous out
    '{16'd220, OP_BOTH, 8'd30, 4'd0, 1'b0, 8'd0,  12'd108, 12'd154}, // R11 store dropped
    '{16'd231, OP_LD,   8'd0,  4'd0, 1'b0, 8'd0,  12'd108, 12'd154}  // R11 queue stayed empty
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [TIME_W-1:0] cyc;
  logic              st_req, ld_req;
  logic [COST_W-1:0] st_cost;
  logic [LEN_W-1:0]  len_cfg;
  logic              stall;
  logic [CNT_W-1:0]  wait_total, store_total;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  sbt_tracker #(
    .DEPTH(DEPTH), .COST_W(COST_W), .TIME_W(TIME_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cycle_now(cyc), .st_req(st_req), .st_cost(st_cost),
    .ld_req(ld_req), .len_cfg(len_cfg), .stall(stall),
    .wait_total(wait_total), .store_total(store_total)
  );

  always #5 clk = ~clk;

  initial begin
    cyc = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 16'd1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request on the edge whose cycle_now equals tgt; return stall length.
  task automatic issue(input int tgt, input logic [1:0] op, input int cost,
                       input int len, input bit poke, output int n);
    len_cfg = LEN_W'(len);
    while (int'(cyc) != tgt) @(negedge clk);
    st_req  = op[0];
    ld_req  = op[1];
    st_cost = COST_W'(cost);
    @(negedge clk);
    st_req = 1'b0;
    ld_req = 1'b0;
    n = 0;
    while (stall) begin
      n++;
      if (poke) begin  // R6: requests during a stall must be ignored
        st_req  = 1'b1;
        ld_req  = 1'b1;
        st_cost = 8'd99;
      end
      @(negedge clk);
    end
    st_req = 1'b0;
    ld_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; st_req = 1'b0; ld_req = 1'b0; st_cost = '0; len_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(stall == 1'b0, "R1 stall", int'(stall), 0);
    check(wait_total == '0, "R1 wait_total", int'(wait_total), 0);
    check(store_total == '0, "R1 store_total", int'(store_total), 0);

    for (int r = 0; r < NROW; r++) begin
      int n;
      issue(int'(ROWS[r].tgt), ROWS[r].op, int'(ROWS[r].cost), int'(ROWS[r].len),
            ROWS[r].poke, n);
      check(n == int'(ROWS[r].exp_stall), $sformatf("R6 stall length row %0d", r),
            n, int'(ROWS[r].exp_stall));
      check(wait_total == ROWS[r].exp_wt, $sformatf("R9 wait_total row %0d", r),
            int'(wait_total), int'(ROWS[r].exp_wt));
      check(store_total == ROWS[r].exp_st, $sformatf("R8 store_total row %0d", r),
            int'(store_total), int'(ROWS[r].exp_st));
    end

    // R10 saturation: store 255 then load next cycle waits 254 each pass
    for (int k = 0; k < 20; k++) begin
      int n;
      int t;
      t = int'(cyc) + 3;
      issue(t, OP_ST, 255, 4, 1'b0, n);
      issue(t + 1, OP_LD, 0, 4, 1'b0, n);
      check(n == 254, "R5 drain stall in saturation loop", n, 254);
      if (k == 14) begin
        check(int'(store_total) == 3979, "R10 store_total below limit", int'(store_total), 3979);
        check(int'(wait_total) == 3918, "R10 wait_total below limit", int'(wait_total), 3918);
      end
    end
    check(int'(store_total) == 4095, "R10 store_total saturated", int'(store_total), 4095);
    check(int'(wait_total) == 4095, "R10 wait_total saturated", int'(wait_total), 4095);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule